// File: doc/BRIEF.md
# Bank-Switched Two-Port Lane Memory

A synchronous memory with two independent access ports on one clock. Each port has a pair of chip selects, a read/not-write strobe, four active-low lane enables, an asynchronous output enable, an 18-bit address and a 36-bit data word. The word is split into four 9-bit lanes, and any subset of lanes can be written or read in one access. The upper address bits pick one of 64 banks. The two ports may work in different banks at the same time. If both address the same bank in one cycle, both accesses are discarded and both ports flag the conflict.

Read data is either flow-through, valid in the cycle after the sampling edge, or pipelined, valid one cycle later. A shared mode input selects between the two. The storage array keeps only a few words per bank so that simulation stays small; the low word-address bits select within a bank. Addresses are supplied by an external counter block. Tri-state drive is modelled as a per-lane output-enable vector, and lanes that are not driven read as zero.

Top module: `bdp_mem_top`

## Requirements
- R1: Lane k of a data word occupies bits 9k+8 down to 9k (lane 0 is bits 8:0, lane 3 is bits 35:27), and writing lane k changes no other lane of the stored word.
- R2: A port is selected only when its chip select 0 is low and chip select 1 is high. A port that is not selected writes nothing, drives no lane and does not take part in bank conflicts.
- R3: Lane enables are active low. A write updates only the enabled lanes. A read sets lane_oe bit k only for enabled lanes, and the rdata bits of lanes that are not driven are zero. With all four enables high, nothing is written or driven.
- R4: The output enable is asynchronous and active low. While it is high, lane_oe is all zero and rdata is zero in the same cycle. When it returns low, the pending read data reappears at once.
- R5: Address bits 17:12 are the bank number and bits 11:0 the word address. Only the low STORE_W (default 3) word bits select storage, so word addresses that differ only above them alias.
- R6: When both ports are selected and their bank numbers are equal, neither port writes. Both conflict outputs are high in the cycle after the sampling edge, and a conflicted read drives its enabled lanes with zero.
- R7: Selected ports in different banks both complete their accesses in the same cycle, and data written through one port is readable through the other.
- R8: With pipe_mode_i low, read data and lane_oe are valid for exactly one cycle: the cycle following the edge that sampled the read.
- R9: With pipe_mode_i high, read data and lane_oe appear one cycle later than in flow-through mode. The conflict flag keeps the flow-through timing.
- R10: During and right after reset, both lane_oe outputs and both conflict outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 0 flow-through reads, 1 pipelined reads |
| ce0_n_a_i | input | 1 | Port A chip select, active low |
| ce1_a_i | input | 1 | Port A chip select, active high |
| rnw_a_i | input | 1 | Port A 1 read, 0 write |
| be_n_a_i | input | 4 | Port A lane enables, active low |
| oe_n_a_i | input | 1 | Port A output enable, active low, asynchronous |
| addr_a_i | input | 18 | Port A bank and word address |
| wdata_a_i | input | 36 | Port A write data |
| rdata_a_o | output | 36 | Port A read data, zero on undriven lanes |
| lane_oe_a_o | output | 4 | Port A per-lane drive enable |
| conflict_a_o | output | 1 | Port A bank conflict flag |
| ce0_n_b_i | input | 1 | Port B chip select, active low |
| ce1_b_i | input | 1 | Port B chip select, active high |
| rnw_b_i | input | 1 | Port B 1 read, 0 write |
| be_n_b_i | input | 4 | Port B lane enables, active low |
| oe_n_b_i | input | 1 | Port B output enable, active low, asynchronous |
| addr_b_i | input | 18 | Port B bank and word address |
| wdata_b_i | input | 36 | Port B write data |
| rdata_b_o | output | 36 | Port B read data, zero on undriven lanes |
| lane_oe_b_o | output | 4 | Port B per-lane drive enable |
| conflict_b_o | output | 1 | Port B bank conflict flag |

## Verification
Most internal faults show up on the first read that follows. A corrupted lane write enable or a wrong storage index makes a later readback return another lane's or another word's data. A missed conflict lets a write through, which a readback in the next cycle exposes as changed data. A stuck or extra pipeline register moves lane_oe by one cycle, so a scoreboard keyed to the expected cycle catches it on the very next read. A fault in the output gate shows up within one cycle, either as a lane driven while the output enable is high or as a lane left undriven after a read.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 9;
  localparam int unsigned BANK_W_DEF = 6;
  localparam int unsigned WORD_W_DEF = 12;
  localparam int unsigned STORE_W_DEF = 3;

  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/bdp_bank_arb.sv
module bdp_bank_arb #(
  parameter int unsigned BANK_W = 6
) (
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic [BANK_W-1:0] bank_a_i,
  input  logic [BANK_W-1:0] bank_b_i,
  output logic              clash_o
);
  assign clash_o = sel_a_i && sel_b_i && (bank_a_i == bank_b_i);
endmodule

// File: rtl/bdp_store.sv
module bdp_store #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned BANK_W = 6,
  parameter int unsigned IDX_W  = 9,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned DEPTH  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  we_a_i,
  input  logic              re_a_i,
  input  logic [IDX_W-1:0]  idx_a_i,
  input  logic [DATA_W-1:0] wd_a_i,
  output logic [DATA_W-1:0] rd_a_o,
  input  logic [LANES-1:0]  we_b_i,
  input  logic              re_b_i,
  input  logic [IDX_W-1:0]  idx_b_i,
  input  logic [DATA_W-1:0] wd_b_i,
  output logic [DATA_W-1:0] rd_b_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_a_q, rd_b_q;

    always_ff @(posedge clk_i) begin
      if (we_a_i[l]) mem_q[idx_a_i] <= wd_a_i[l*LANE_W +: LANE_W];
      if (we_b_i[l]) mem_q[idx_b_i] <= wd_b_i[l*LANE_W +: LANE_W];
      if (re_a_i) rd_a_q <= mem_q[idx_a_i];
      if (re_b_i) rd_b_q <= mem_q[idx_b_i];
    end

    assign rd_a_o[l*LANE_W +: LANE_W] = rd_a_q;
    assign rd_b_o[l*LANE_W +: LANE_W] = rd_b_q;
  end

  // two ports never write one bank in the same cycle
  assert_no_dual_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|we_a_i) && (|we_b_i)) |-> (idx_a_i[IDX_W-1 -: BANK_W] != idx_b_i[IDX_W-1 -: BANK_W]));
endmodule

// File: rtl/bdp_port.sv
module bdp_port
  import bdp_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_W  = 9,
  parameter int unsigned BANK_W  = 6,
  parameter int unsigned WORD_W  = 12,
  parameter int unsigned STORE_W = 3,
  localparam int unsigned ADDR_W = BANK_W + WORD_W,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned IDX_W  = BANK_W + STORE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rd_mode_e          mode_i,
  input  logic              ce0_n_i,
  input  logic              ce1_i,
  input  logic              rnw_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clash_i,
  output logic              sel_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic              re_o,
  input  logic [DATA_W-1:0] mem_rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  lane_oe_o,
  output logic              conflict_o
);
  logic [LANES-1:0]  lanes_on;
  logic [LANES-1:0]  s1_mask_q, s2_mask_q, mask_sel;
  logic              s1_void_q, conf_q;
  logic [DATA_W-1:0] s1_data, s2_data_q, data_sel;
  logic              unused_word_hi;

  assign lanes_on       = ~be_n_i;
  assign sel_o          = !ce0_n_i && ce1_i;
  assign bank_o         = addr_i[ADDR_W-1 -: BANK_W];
  assign idx_o          = {bank_o, addr_i[STORE_W-1:0]};
  assign unused_word_hi = ^addr_i[WORD_W-1:STORE_W];
  assign lane_we_o      = (sel_o && !rnw_i && !clash_i) ? lanes_on : '0;
  assign re_o           = sel_o && rnw_i && !clash_i && (|lanes_on);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_mask_q <= '0;
      s1_void_q <= 1'b0;
      conf_q    <= 1'b0;
      s2_mask_q <= '0;
      s2_data_q <= '0;
    end else begin
      s1_mask_q <= (sel_o && rnw_i) ? lanes_on : '0;
      s1_void_q <= clash_i;
      conf_q    <= sel_o && clash_i;
      s2_mask_q <= s1_mask_q;
      s2_data_q <= s1_data;
    end
  end

  // conflicted reads return zero instead of stale array output
  assign s1_data    = s1_void_q ? '0 : mem_rd_i;
  assign mask_sel   = (mode_i == RD_PIPE) ? s2_mask_q : s1_mask_q;
  assign data_sel   = (mode_i == RD_PIPE) ? s2_data_q : s1_data;
  assign lane_oe_o  = oe_n_i ? '0 : mask_sel;
  assign conflict_o = conf_q;

  for (genvar l = 0; l < LANES; l++) begin : g_gate
    assign rdata_o[l*LANE_W +: LANE_W] = lane_oe_o[l] ? data_sel[l*LANE_W +: LANE_W] : '0;
  end

  assert_deselect_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RD_FLOW && $past(mode_i) == RD_FLOW && $past(!sel_o)) |-> (lane_oe_o == '0));

  assert_lane_subset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RD_FLOW && $past(mode_i) == RD_FLOW) |-> ((lane_oe_o & $past(be_n_i)) == '0));

  assert_flow_timing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RD_FLOW && $past(mode_i) == RD_FLOW && $past(sel_o && rnw_i))
      |-> (lane_oe_o == ($past(lanes_on) & {LANES{!oe_n_i}})));
endmodule

// File: rtl/bdp_mem_top.sv
module bdp_mem_top
  import bdp_pkg::*;
#(
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned LANE_W  = LANE_W_DEF,
  parameter int unsigned BANK_W  = BANK_W_DEF,
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned STORE_W = STORE_W_DEF,
  localparam int unsigned ADDR_W = BANK_W + WORD_W,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned IDX_W  = BANK_W + STORE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              ce0_n_a_i,
  input  logic              ce1_a_i,
  input  logic              rnw_a_i,
  input  logic [LANES-1:0]  be_n_a_i,
  input  logic              oe_n_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [LANES-1:0]  lane_oe_a_o,
  output logic              conflict_a_o,
  input  logic              ce0_n_b_i,
  input  logic              ce1_b_i,
  input  logic              rnw_b_i,
  input  logic [LANES-1:0]  be_n_b_i,
  input  logic              oe_n_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [LANES-1:0]  lane_oe_b_o,
  output logic              conflict_b_o
);
  rd_mode_e          mode;
  logic              sel_a, sel_b, clash, re_a, re_b;
  logic [BANK_W-1:0] bank_a, bank_b;
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic [LANES-1:0]  we_a, we_b;
  logic [DATA_W-1:0] mrd_a, mrd_b;

  assign mode = rd_mode_e'(pipe_mode_i);

  bdp_bank_arb #(.BANK_W(BANK_W)) u_arb (
    .sel_a_i(sel_a), .sel_b_i(sel_b), .bank_a_i(bank_a), .bank_b_i(bank_b), .clash_o(clash)
  );

  bdp_port #(.LANES(LANES), .LANE_W(LANE_W), .BANK_W(BANK_W), .WORD_W(WORD_W), .STORE_W(STORE_W)) u_port_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
    .ce0_n_i(ce0_n_a_i), .ce1_i(ce1_a_i), .rnw_i(rnw_a_i), .be_n_i(be_n_a_i), .oe_n_i(oe_n_a_i),
    .addr_i(addr_a_i), .clash_i(clash), .sel_o(sel_a), .bank_o(bank_a), .idx_o(idx_a),
    .lane_we_o(we_a), .re_o(re_a), .mem_rd_i(mrd_a),
    .rdata_o(rdata_a_o), .lane_oe_o(lane_oe_a_o), .conflict_o(conflict_a_o)
  );

  bdp_port #(.LANES(LANES), .LANE_W(LANE_W), .BANK_W(BANK_W), .WORD_W(WORD_W), .STORE_W(STORE_W)) u_port_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
    .ce0_n_i(ce0_n_b_i), .ce1_i(ce1_b_i), .rnw_i(rnw_b_i), .be_n_i(be_n_b_i), .oe_n_i(oe_n_b_i),
    .addr_i(addr_b_i), .clash_i(clash), .sel_o(sel_b), .bank_o(bank_b), .idx_o(idx_b),
    .lane_we_o(we_b), .re_o(re_b), .mem_rd_i(mrd_b),
    .rdata_o(rdata_b_o), .lane_oe_o(lane_oe_b_o), .conflict_o(conflict_b_o)
  );

  bdp_store #(.LANES(LANES), .LANE_W(LANE_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_a_i(we_a), .re_a_i(re_a), .idx_a_i(idx_a), .wd_a_i(wdata_a_i), .rd_a_o(mrd_a),
    .we_b_i(we_b), .re_b_i(re_b), .idx_b_i(idx_b), .wd_b_i(wdata_b_i), .rd_b_o(mrd_b)
  );

  assert_conflict_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_a_o == conflict_b_o);

  assert_conflict_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_a_o && !pipe_mode_i && !$past(pipe_mode_i)) |-> (rdata_a_o == '0 && rdata_b_o == '0));
endmodule

// File: tb/bdp_mem_top_test.sv
module bdp_mem_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pipe_mode = 1'b0;
  logic        ce0_n_a = 1'b1, ce1_a = 1'b0, rnw_a = 1'b1, oe_n_a = 1'b0;
  logic        ce0_n_b = 1'b1, ce1_b = 1'b0, rnw_b = 1'b1, oe_n_b = 1'b0;
  logic [3:0]  be_n_a = 4'hF, be_n_b = 4'hF;
  logic [17:0] addr_a = '0, addr_b = '0;
  logic [35:0] wdata_a = '0, wdata_b = '0;
  logic [35:0] rdata_a, rdata_b;
  logic [3:0]  lane_oe_a, lane_oe_b;
  logic        conflict_a, conflict_b;

  always #10 clk = ~clk;

  bdp_mem_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .pipe_mode_i(pipe_mode),
    .ce0_n_a_i(ce0_n_a), .ce1_a_i(ce1_a), .rnw_a_i(rnw_a), .be_n_a_i(be_n_a), .oe_n_a_i(oe_n_a),
    .addr_a_i(addr_a), .wdata_a_i(wdata_a), .rdata_a_o(rdata_a), .lane_oe_a_o(lane_oe_a),
    .conflict_a_o(conflict_a),
    .ce0_n_b_i(ce0_n_b), .ce1_b_i(ce1_b), .rnw_b_i(rnw_b), .be_n_b_i(be_n_b), .oe_n_b_i(oe_n_b),
    .addr_b_i(addr_b), .wdata_b_i(wdata_b), .rdata_b_o(rdata_b), .lane_oe_b_o(lane_oe_b),
    .conflict_b_o(conflict_b)
  );

  typedef struct {
    int          cemode; // 0 selected, 1 ce0_n high, 2 ce1 low
    bit          rd;
    bit [3:0]    be_n;
    bit [5:0]    bank;
    bit [11:0]   word;
    bit [35:0]   wd;
  } op_t;

  typedef struct {
    int        due;
    int        port;
    bit        is_conf;
    bit [3:0]  mask;
    bit [35:0] data;
    bit        conf;
    string     tag;
  } exp_t;

  exp_t       sb_q[$];
  bit [35:0]  model [int];
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  function automatic op_t mk(int cm, bit rd, bit [3:0] be_n, bit [5:0] bank, bit [11:0] word, bit [35:0] wd);
    op_t o;
    o.cemode = cm; o.rd = rd; o.be_n = be_n; o.bank = bank; o.word = word; o.wd = wd;
    return o;
  endfunction

  function automatic op_t idle_op();
    return mk(1, 1'b1, 4'hF, 6'd0, 12'd0, 36'd0);
  endfunction

  function automatic int key(op_t o);
    return int'({o.bank, o.word[2:0]});
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic drive(op_t a, op_t b);
    ce0_n_a = (a.cemode == 1); ce1_a = (a.cemode != 2); rnw_a = a.rd; be_n_a = a.be_n;
    addr_a = {a.bank, a.word}; wdata_a = a.wd;
    ce0_n_b = (b.cemode == 1); ce1_b = (b.cemode != 2); rnw_b = b.rd; be_n_b = b.be_n;
    addr_b = {b.bank, b.word}; wdata_b = b.wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(idle_op(), idle_op());
    end
  endtask

  task automatic run(op_t a, op_t b, string tag);
    bit        clash;
    int        due_d;
    op_t       ops [2];
    @(negedge clk);
    drive(a, b);
    ops[0] = a; ops[1] = b;
    clash = (a.cemode == 0) && (b.cemode == 0) && (a.bank == b.bank);
    due_d = cyc + (pipe_mode ? 2 : 1);
    for (int p = 0; p < 2; p++) begin
      exp_t e;
      e.port = p; e.tag = tag;
      e.due = due_d; e.is_conf = 1'b0; e.conf = 1'b0; e.mask = '0; e.data = '0;
      if (ops[p].cemode == 0 && ops[p].rd) begin
        e.mask = ~ops[p].be_n;
        for (int l = 0; l < 4; l++)
          if (e.mask[l] && !clash) e.data[l*9 +: 9] = model[key(ops[p])][l*9 +: 9];
      end
      sb_q.push_back(e);
      e.due = cyc + 1; e.is_conf = 1'b1; e.conf = clash; e.mask = '0; e.data = '0;
      sb_q.push_back(e);
    end
    for (int p = 0; p < 2; p++) begin
      if (ops[p].cemode == 0 && !ops[p].rd && !clash) begin
        bit [35:0] w;
        w = model.exists(key(ops[p])) ? model[key(ops[p])] : 36'd0;
        for (int l = 0; l < 4; l++)
          if (!ops[p].be_n[l]) w[l*9 +: 9] = ops[p].wd[l*9 +: 9];
        model[key(ops[p])] = w;
      end
    end
  endtask

  // monitor: pop and compare the items due this cycle
  always @(posedge clk) begin
    cyc++;
    #5;
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        exp_t e;
        e = sb_q[i];
        if (e.is_conf)
          check(e.tag, {63'd0, (e.port == 0) ? conflict_a : conflict_b}, {63'd0, e.conf},
                (e.port == 0) ? "conflict A" : "conflict B");
        else begin
          check(e.tag, {60'd0, (e.port == 0) ? lane_oe_a : lane_oe_b}, {60'd0, e.mask},
                (e.port == 0) ? "lane_oe A" : "lane_oe B");
          check(e.tag, {28'd0, (e.port == 0) ? rdata_a : rdata_b}, {28'd0, e.data},
                (e.port == 0) ? "rdata A" : "rdata B");
        end
        sb_q.delete(i);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    localparam bit [35:0] D1 = 36'h1_2345_6789, D2 = 36'hA_BCDE_F012, D3 = 36'h5_5AA5_5AA5;
    localparam bit [35:0] D4 = 36'hF_FFFF_FFFF, D5 = 36'h3_C3C3_C3C3, D6 = 36'h0_F0F0_F0F0;
    localparam bit [35:0] D7 = 36'h9_8765_4321, D8 = 36'h6_1616_1616, D9 = 36'h2_4682_4682;
    localparam bit [35:0] D10 = 36'h7_7777_0000, D11 = 36'hE_0E0E_0E0E;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #5;
    // R10: reset state
    check("R10", {60'd0, lane_oe_a}, 64'd0, "lane_oe A after reset");
    check("R10", {60'd0, lane_oe_b}, 64'd0, "lane_oe B after reset");
    check("R10", {62'd0, conflict_a, conflict_b}, 64'd0, "conflict after reset");

    // flow-through mode
    run(mk(0, 0, 4'h0, 6'd3, 12'd1, D6), mk(0, 0, 4'h0, 6'd4, 12'd0, D7), "R7 init");
    run(mk(0, 0, 4'h0, 6'd1, 12'd2, D1), mk(0, 0, 4'h0, 6'd2, 12'd5, D2), "R7 dual write");
    run(mk(0, 1, 4'h0, 6'd2, 12'd5, D1), mk(0, 1, 4'h0, 6'd1, 12'd2, D2), "R7 R8 cross read");
    run(mk(0, 0, 4'b1010, 6'd1, 12'd2, D3), mk(1, 0, 4'h0, 6'd2, 12'd5, D4), "R1 R2 lane write");
    run(mk(0, 1, 4'h0, 6'd1, 12'd2, 0), mk(0, 1, 4'b0110, 6'd2, 12'd5, 0), "R1 R3 lane read");
    run(mk(0, 1, 4'hF, 6'd1, 12'd2, 0), mk(2, 1, 4'h0, 6'd2, 12'd5, 0), "R2 R3 no lanes");
    run(mk(0, 0, 4'h0, 6'd3, 12'd1, D5), mk(0, 1, 4'h0, 6'd3, 12'd1, 0), "R6 write-read clash");
    run(mk(0, 1, 4'h0, 6'd3, 12'd1, 0), mk(0, 1, 4'h0, 6'd4, 12'd0, 0), "R6 write suppressed");
    run(mk(0, 0, 4'h0, 6'd6, 12'd0, D9), mk(0, 0, 4'h0, 6'd7, 12'd0, D10), "R7 init2");
    run(mk(0, 0, 4'h0, 6'd7, 12'd0, D4), mk(0, 0, 4'h0, 6'd7, 12'd0, D5), "R6 dual write clash");
    run(mk(0, 1, 4'h0, 6'd6, 12'd0, 0), mk(0, 1, 4'h0, 6'd7, 12'd0, 0), "R6 both unchanged");
    run(mk(0, 0, 4'h0, 6'd6, 12'd0, D11), mk(1, 0, 4'h0, 6'd6, 12'd0, D2), "R2 no clash deselected");
    run(mk(0, 1, 4'h0, 6'd6, 12'd0, 0), idle_op(), "R2 write landed");
    run(mk(0, 0, 4'h0, 6'd5, 12'h00A, D8), idle_op(), "R5 alias write");
    run(mk(0, 1, 4'h0, 6'd5, 12'h002, 0), mk(0, 1, 4'h0, 6'd5, 12'hFF2, 0), "R5 R6 alias read clash");
    run(mk(0, 1, 4'h0, 6'd5, 12'h7F2, 0), idle_op(), "R5 alias read");
    run(idle_op(), idle_op(), "R8 one cycle valid");

    // R4: asynchronous output enable
    @(negedge clk);
    drive(mk(0, 1, 4'h0, 6'd1, 12'd2, 0), idle_op());
    @(posedge clk); #6;
    check("R4", {60'd0, lane_oe_a}, 64'hF, "lane_oe A before oe");
    check("R4", {28'd0, rdata_a}, {28'd0, model[int'({6'd1, 3'd2})]}, "rdata A before oe");
    oe_n_a = 1'b1; #1;
    check("R4", {60'd0, lane_oe_a}, 64'd0, "lane_oe A with oe high");
    check("R4", {28'd0, rdata_a}, 64'd0, "rdata A with oe high");
    oe_n_a = 1'b0; #1;
    check("R4", {60'd0, lane_oe_a}, 64'hF, "lane_oe A oe restored");
    idle(3);

    // pipelined mode
    pipe_mode = 1'b1;
    idle(3);
    run(mk(0, 1, 4'h0, 6'd1, 12'd2, 0), mk(0, 1, 4'h0, 6'd2, 12'd5, 0), "R9 pipe read");
    run(mk(0, 1, 4'b1100, 6'd1, 12'd2, 0), mk(0, 1, 4'h0, 6'd4, 12'd0, 0), "R9 R3 pipe lanes");
    run(mk(0, 0, 4'h0, 6'd3, 12'd1, D8), mk(0, 1, 4'h0, 6'd3, 12'd1, 0), "R9 R6 pipe clash");
    run(mk(0, 1, 4'h0, 6'd3, 12'd1, 0), idle_op(), "R9 R6 pipe unchanged");
    run(idle_op(), idle_op(), "R9 pipe idle");
    idle(3);

    // back to flow-through
    pipe_mode = 1'b0;
    idle(3);
    run(mk(0, 1, 4'h0, 6'd2, 12'd5, 0), mk(0, 1, 4'h0, 6'd1, 12'd2, 0), "R8 flow again");
    run(idle_op(), idle_op(), "R8 drop after one cycle");
    repeat (4) @(posedge clk);
    #7;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule